// File: doc/BRIEF.md
# Pin Event Detector with Interrupt and DMA Routing

This block watches a bank of external pin inputs and raises a sticky per-pin event flag when the input shows a chosen edge or level. Each pin has its own 4-bit trigger code. The code selects the trigger: rising edge, falling edge, any edge, held low or held high. It also selects where a set flag is routed: to that pin's DMA request line, or into a single combined interrupt line. Each input first passes through a two-stage synchronizer. Edges are found by comparing the synchronized sample with the sample one cycle older.

Software clears flags by writing 1. It can do so through the flag field of one selected pin's control register, or through a status word that holds one bit per pin. A flag on a DMA-routed pin also clears itself when the DMA engine pulses that pin's completion input. Level triggers keep the flag set for as long as the pin stays at the active level. If an event and a clear arrive in the same cycle, the event wins.

Top module: `pin_event_detector`

## Requirements
- R1: After a synchronous reset, `flags`, `dma_req` and `irq` are all zero.
- R2: Codes 4'b0001 and 4'b1001 set the pin's flag on a 0-to-1 change of the synchronized input. If `pin_in` changes before clock edge k, the flag reads 1 after edge k+2.
- R3: Codes 4'b0010 and 4'b1010 set the flag on a 1-to-0 change of the synchronized input, with the same latency as R2.
- R4: Codes 4'b0011 and 4'b1011 set the flag on any change of the synchronized input.
- R5: Code 4'b1000 sets the flag while the synchronized input is 0, and code 4'b1100 sets it while the input is 1. A clear issued while the pin is still at the active level leaves the flag reading 1 on the next cycle.
- R6: Code 4'b0000 and the unused codes (4'b0100 to 4'b0111 and 4'b1101 to 4'b1111) never set a flag.
- R7: A set flag stays set until it is cleared. A per-pin write with `pin_wr_flag`=0, or a status write with a 0 in that pin's bit, has no effect on the flag.
- R8: A per-pin write (`pin_wr_en`=1, `pin_wr_flag`=1) clears only the flag of the pin indexed by `pin_wr_sel`.
- R9: A status write (`stat_wr_en`=1) clears every flag whose bit in `stat_wr_data` is 1.
- R10: `dma_done[i]` clears flag i when pin i has a DMA code (4'b0001 to 4'b0011). It has no effect under any other code.
- R11: `dma_req[i]` is flag i when pin i has a DMA code, and 0 otherwise. `irq` is the OR of the flags of all pins whose code is an interrupt code (4'b1000 to 4'b1100).
- R12: When an event and a clear hit the same pin in the same cycle, the flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| cfg_code | input | 4*NUM_PINS | Trigger code of pin i in bits [4i+3:4i] |
| pin_wr_en | input | 1 | Write strobe for one pin's control register |
| pin_wr_sel | input | $clog2(NUM_PINS) | Index of the pin being written |
| pin_wr_flag | input | 1 | Value written to the flag field (1 clears) |
| stat_wr_en | input | 1 | Write strobe for the status word |
| stat_wr_data | input | NUM_PINS | Status word data, 1 clears the matching flag |
| dma_done | input | NUM_PINS | Per-pin DMA transfer completion pulse |
| flags | output | NUM_PINS | Current event flags (status word read value) |
| dma_req | output | NUM_PINS | Per-pin DMA request |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: 32 pins and two synchronizer stages. This puts every one of the 32 detector cells under test, along with the full width of the status word and a 5-bit pin select that reaches the last pin. Keeping two synchronizer stages fixes the edge-to-flag latency at three clock edges. The directed cases depend on that latency, for example the case that lands a clear in the same cycle as an edge event. Random phases redraw all sixteen codes across the 32 pins, so the reserved codes, both routes and every trigger kind run side by side.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        ROUTE_OFF = 2'd0,
        ROUTE_DMA = 2'd1,
        ROUTE_IRQ = 2'd2
    } route_e;

    typedef enum logic [2:0] {
        TRIG_NONE = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_BOTH = 3'd3,
        TRIG_LOW  = 3'd4,
        TRIG_HIGH = 3'd5
    } trig_e;

    typedef struct packed {
        route_e route;
        trig_e  trig;
    } evt_cfg_t;

    // Map a pin trigger code to its routing group and trigger kind.
    function automatic evt_cfg_t decode_code(input logic [CODE_W-1:0] code);
        evt_cfg_t c;
        c.route = ROUTE_OFF;
        c.trig  = TRIG_NONE;
        case (code)
            4'b0001: begin c.route = ROUTE_DMA; c.trig = TRIG_RISE; end
            4'b0010: begin c.route = ROUTE_DMA; c.trig = TRIG_FALL; end
            4'b0011: begin c.route = ROUTE_DMA; c.trig = TRIG_BOTH; end
            4'b1000: begin c.route = ROUTE_IRQ; c.trig = TRIG_LOW;  end
            4'b1001: begin c.route = ROUTE_IRQ; c.trig = TRIG_RISE; end
            4'b1010: begin c.route = ROUTE_IRQ; c.trig = TRIG_FALL; end
            4'b1011: begin c.route = ROUTE_IRQ; c.trig = TRIG_BOTH; end
            4'b1100: begin c.route = ROUTE_IRQ; c.trig = TRIG_HIGH; end
            default: begin c.route = ROUTE_OFF; c.trig = TRIG_NONE; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
    import pin_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              level,
    input  logic              clr_w1c,
    input  logic              dma_done,
    output logic              flag,
    output logic              dma_req,
    output logic              irq_req
);

    evt_cfg_t cfg;
    logic     prev_q;
    logic     flag_q;
    logic     hit;
    logic     clr_all;

    assign cfg = decode_code(code);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    always_comb begin
        case (cfg.trig)
            TRIG_RISE: hit = level & ~prev_q;
            TRIG_FALL: hit = ~level & prev_q;
            TRIG_BOTH: hit = level ^ prev_q;
            TRIG_LOW:  hit = ~level;
            TRIG_HIGH: hit = level;
            default:   hit = 1'b0;
        endcase
    end

    assign clr_all = clr_w1c | (dma_done & (cfg.route == ROUTE_DMA));

    // Detection has priority over any clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= hit | (flag_q & ~clr_all);
    end

    assign flag    = flag_q;
    assign dma_req = flag_q & (cfg.route == ROUTE_DMA);
    assign irq_req = flag_q & (cfg.route == ROUTE_IRQ);

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_all) |=> flag_q);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_w1c && !dma_done) |=> flag_q);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_w1c && !hit) |=> !flag_q);

    assert_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg.route == ROUTE_OFF && !flag_q) |=> !flag_q);

    assert_level_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg.trig == TRIG_HIGH && level) |=> flag_q);

    assert_route_R11: assert property (@(posedge clk) disable iff (rst)
        !(dma_req && irq_req));

endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PINS-1:0]        pin_in,
    input  logic [NUM_PINS*CODE_W-1:0] cfg_code,
    input  logic                       pin_wr_en,
    input  logic [IDX_W-1:0]           pin_wr_sel,
    input  logic                       pin_wr_flag,
    input  logic                       stat_wr_en,
    input  logic [NUM_PINS-1:0]        stat_wr_data,
    input  logic [NUM_PINS-1:0]        dma_done,
    output logic [NUM_PINS-1:0]        flags,
    output logic [NUM_PINS-1:0]        dma_req,
    output logic                       irq
);

    logic [NUM_PINS-1:0] level_s;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] irq_vec;

    pin_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (level_s)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic pin_hit_sel;
        assign pin_hit_sel = pin_wr_en && pin_wr_flag && (pin_wr_sel == IDX_W'(i));
        assign clr_vec[i]  = pin_hit_sel | (stat_wr_en & stat_wr_data[i]);

        pin_evt_cell cell_i (
            .clk      (clk),
            .rst      (rst),
            .code     (cfg_code[i*CODE_W +: CODE_W]),
            .level    (level_s[i]),
            .clr_w1c  (clr_vec[i]),
            .dma_done (dma_done[i]),
            .flag     (flags[i]),
            .dma_req  (dma_req[i]),
            .irq_req  (irq_vec[i])
        );
    end

    assign irq = |irq_vec;

    assert_irq_src_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

    assert_dma_src_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(dma_req) <= $countones(flags));

endmodule

// File: tb/pin_event_detector_tb_top.sv
`timescale 1ns/1ps
module pin_event_detector_tb_top;

    localparam int N     = 32;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst;
    logic [N-1:0]     pin_in;
    logic [N*4-1:0]   cfg_code;
    logic             pin_wr_en;
    logic [IDX_W-1:0] pin_wr_sel;
    logic             pin_wr_flag;
    logic             stat_wr_en;
    logic [N-1:0]     stat_wr_data;
    logic [N-1:0]     dma_done;
    logic [N-1:0]     flags;
    logic [N-1:0]     dma_req;
    logic             irq;

    int errors = 0;
    int checks = 0;

    // Bench reference state
    logic [N-1:0] m_s1, m_sync, m_prev, m_flag;

    always #5 clk = ~clk;

    pin_event_detector #(.NUM_PINS(N), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_code(cfg_code),
        .pin_wr_en(pin_wr_en), .pin_wr_sel(pin_wr_sel), .pin_wr_flag(pin_wr_flag),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .dma_done(dma_done),
        .flags(flags), .dma_req(dma_req), .irq(irq)
    );

    function automatic int grp(input logic [3:0] c);
        if (c >= 4'd1 && c <= 4'd3) return 1;
        if (c >= 4'd8 && c <= 4'd12) return 2;
        return 0;
    endfunction

    function automatic logic trig(input logic [3:0] c, input logic s, input logic p);
        case (c)
            4'd1, 4'd9:  return s & ~p;
            4'd2, 4'd10: return ~s & p;
            4'd3, 4'd11: return s ^ p;
            4'd8:        return ~s;
            4'd12:       return s;
            default:     return 1'b0;
        endcase
    endfunction

    function automatic logic [N-1:0] exp_dma();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_flag[i] && grp(cfg_code[i*4 +: 4]) == 1;
        return v;
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int i = 0; i < N; i++) r |= m_flag[i] && grp(cfg_code[i*4 +: 4]) == 2;
        return r;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: update the reference at the edge, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_s1 = '0; m_sync = '0; m_prev = '0; m_flag = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                logic [3:0] c;
                logic ev, cl;
                c  = cfg_code[i*4 +: 4];
                ev = trig(c, m_sync[i], m_prev[i]);
                cl = (pin_wr_en && pin_wr_flag && pin_wr_sel == IDX_W'(i))
                   || (stat_wr_en && stat_wr_data[i])
                   || (dma_done[i] && grp(c) == 1);
                m_flag[i] = ev | (m_flag[i] & ~cl);
            end
            m_prev = m_sync; m_sync = m_s1; m_s1 = pin_in;
        end
        @(negedge clk);
        check("R7 flags vs model", flags, m_flag);
        check("R11 dma_req vs model", dma_req, exp_dma());
        check("R11 irq vs model", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, exp_irq()});
    endtask

    task automatic idle_ctl();
        pin_wr_en = 0; pin_wr_flag = 0; pin_wr_sel = '0;
        stat_wr_en = 0; stat_wr_data = '0; dma_done = '0;
    endtask

    task automatic set_code(input int i, input logic [3:0] c);
        cfg_code[i*4 +: 4] = c;
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; pin_in = '0; cfg_code = '0; idle_ctl();
        steps(3);
        rst = 0;
        step();
        check("R1 flags after reset", flags, '0);
        check("R1 dma_req after reset", dma_req, '0);
        check("R1 irq after reset", {31'd0, irq}, '0);

        // R2: rising edge on a DMA pin, exact latency
        set_code(0, 4'b0001);
        pin_in[0] = 1;
        step(); step();
        check("R2 not yet set after two edges", {31'd0, flags[0]}, '0);
        step();
        check("R2 rising sets flag", {31'd0, flags[0]}, 32'd1);
        check("R11 dma_req on DMA pin", {31'd0, dma_req[0]}, 32'd1);
        check("R11 no irq from DMA pin", {31'd0, irq}, '0);

        // R7: writes of zero leave the flag
        pin_wr_en = 1; pin_wr_sel = 0; pin_wr_flag = 0; step();
        idle_ctl(); stat_wr_en = 1; stat_wr_data = '0; step(); idle_ctl();
        check("R7 zero writes ignored", {31'd0, flags[0]}, 32'd1);

        // R10: DMA completion clears DMA pin
        dma_done[0] = 1; step(); idle_ctl();
        check("R10 dma_done clears", {31'd0, flags[0]}, '0);

        // R3: falling edge on interrupt pin
        pin_in[1] = 1; steps(4);
        set_code(1, 4'b1010);
        pin_in[1] = 0; steps(3);
        check("R3 falling sets flag", {31'd0, flags[1]}, 32'd1);
        check("R11 irq from interrupt pin", {31'd0, irq}, 32'd1);

        // R10: dma_done does nothing under interrupt code
        dma_done[1] = 1; step(); idle_ctl();
        check("R10 dma_done ignored on irq pin", {31'd0, flags[1]}, 32'd1);

        // R8: per-pin clear only hits selected pin
        set_code(5, 4'b1001); pin_in[5] = 1; steps(3);
        pin_wr_en = 1; pin_wr_flag = 1; pin_wr_sel = 5; step(); idle_ctl();
        check("R8 selected pin cleared", {31'd0, flags[5]}, '0);
        check("R8 other pin kept", {31'd0, flags[1]}, 32'd1);

        // R4 + R9: both edges, status clear
        set_code(2, 4'b1011); pin_in[2] = 1; steps(3);
        check("R4 rise seen", {31'd0, flags[2]}, 32'd1);
        stat_wr_en = 1; stat_wr_data = 32'h0000_0006; step(); idle_ctl();
        check("R9 status clear", flags & 32'h6, '0);
        pin_in[2] = 0; steps(3);
        check("R4 fall seen", {31'd0, flags[2]}, 32'd1);

        // R5: low level re-asserts after clear
        set_code(3, 4'b1000); steps(2);
        check("R5 low level sets", {31'd0, flags[3]}, 32'd1);
        pin_wr_en = 1; pin_wr_flag = 1; pin_wr_sel = 3; step(); idle_ctl();
        check("R5 flag persists while level active", {31'd0, flags[3]}, 32'd1);
        pin_in[3] = 1; steps(3);
        stat_wr_en = 1; stat_wr_data = 32'h8; step(); idle_ctl();
        check("R5 clears once level gone", {31'd0, flags[3]}, '0);

        // R6: reserved code
        set_code(4, 4'b0101);
        for (int k = 0; k < 6; k++) begin pin_in[4] = ~pin_in[4]; steps(2); end
        check("R6 reserved code inert", {31'd0, flags[4]}, '0);

        // R12: clear lands in same cycle as edge event
        set_code(6, 4'b1001); pin_in[6] = 1; steps(3);
        pin_in[6] = 0; steps(3);
        pin_in[6] = 1; step(); step();
        stat_wr_en = 1; stat_wr_data = 32'h40; step(); idle_ctl();
        check("R12 set wins over clear", {31'd0, flags[6]}, 32'd1);

        // Random phases
        for (int ph = 0; ph < 15; ph++) begin
            for (int i = 0; i < N; i++) set_code(i, 4'($urandom));
            for (int cyc = 0; cyc < 200; cyc++) begin
                pin_in ^= $urandom & $urandom & $urandom;
                idle_ctl();
                if (($urandom & 7) == 0) begin stat_wr_en = 1; stat_wr_data = $urandom; end
                if (($urandom & 3) == 0) begin
                    pin_wr_en = 1; pin_wr_sel = IDX_W'($urandom); pin_wr_flag = 1'($urandom);
                end
                dma_done = $urandom & $urandom;
                step();
            end
        end
        idle_ctl();
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule